// File: doc/BRIEF.md
# Shared SRAM Processor Bus Glue

This block sits between a soft processor's simple memory request bus and one external asynchronous SRAM that doubles as a video frame buffer. The processor asks for a transfer by raising a read or a write strobe along with a word address, two byte-lane enables and, for writes, a 16-bit data word. The glue reacts only to the rising edge of a strobe, and only when the upper address bits select this SRAM's window. It then takes the SRAM pins for a fixed three-cycle access and answers with a one-cycle acknowledge, at which point read data is ready on the return bus.

Outside those three cycles the SRAM address comes from the video pixel fetch. The video path is never stalled. During a processor access it simply sees whatever word is on the SRAM data bus. This can show up as a brief glitch on screen, but it costs no display timing.

Top module: `sram_share_glue`

## Requirements
- R1: An access starts only on a cycle where the read strobe or the write strobe has just gone from low to high (the write strobe wins if both rise together) and the address tag `cpu_addr[CPU_AW-1:SRAM_AW]` equals `WIN_TAG`.
- R2: A strobe edge whose tag differs from `WIN_TAG` causes no SRAM write, drives no SRAM data and produces no acknowledge, and the SRAM address keeps following `vid_addr`.
- R3: `cpu_ack` is high for exactly one cycle. It is set by the third clock edge after the edge that accepted the request.
- R4: For the three cycles after an accepted request, `sram_addr` equals `cpu_addr[SRAM_AW-1:0]` as captured at acceptance. In every other cycle it equals `vid_addr`.
- R5: On a write, `sram_we_n` is low only in the second of the three access cycles. `sram_dq_o` carries the write word with `sram_dq_oe` high for all three cycles. `sram_ub_n` equals the inverse of `cpu_be[1]` (bits 15:8), `sram_lb_n` equals the inverse of `cpu_be[0]` (bits 7:0), and `sram_oe_n` is high.
- R6: On a read, both lane selects and `sram_oe_n` are low. The SRAM word is registered into `cpu_rdata` at the edge that raises `cpu_ack`. `cpu_rdata` then holds until the next read completes, and writes leave it unchanged.
- R7: A strobe edge that arrives while an access is in its three cycles is ignored and does not add an acknowledge.
- R8: A strobe held high after its acknowledge does not start a further access.
- R9: `vid_pix` equals the SRAM data bus in every cycle, so during a processor write it shows the processor's write word.
- R10: During and right after reset, `cpu_ack` is 0, `sram_we_n` is 1, `cpu_rdata` is 0 and `sram_addr` follows `vid_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_addr | input | CPU_AW | Processor word address |
| cpu_be | input | 2 | Byte-lane enables (bit 1 upper byte) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| vid_addr | input | SRAM_AW | Video pixel fetch address |
| vid_pix | output | 16 | Word seen by the video path |
| sram_addr | output | SRAM_AW | SRAM address pins |
| sram_dq_o | output | 16 | SRAM data out |
| sram_dq_oe | output | 1 | SRAM data output enable |
| sram_dq_i | input | 16 | SRAM data in |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_ub_n | output | 1 | Upper byte select, active low |
| sram_lb_n | output | 1 | Lower byte select, active low |

## Verification
The assertions check timing relations on every cycle:
- the acknowledge is a single pulse and always follows an acceptance by a fixed distance;
- the write strobe is a single cycle and always sits two edges after an acceptance;
- no acceptance happens while an access is active;
- the read data register is still except at an acknowledge.

The bench's scenarios are needed for the rest:
- merging byte lanes and reading the merged words back;
- out-of-window edges leaving the SRAM alone;
- strobes held high or re-raised mid-access;
- the video path showing processor data during a write.

// File: rtl/sram_share_pkg.sv
package sram_share_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANES  = 2;

  function automatic logic [LANES-1:0] lane_sel_n(input logic is_wr, input logic [LANES-1:0] be);
    return is_wr ? ~be : '0;
  endfunction

  function automatic logic rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/sram_req_detect.sv
module sram_req_detect #(
  parameter int unsigned CPU_AW  = 24,
  parameter int unsigned SRAM_AW = 20,
  parameter logic [CPU_AW-SRAM_AW-1:0] WIN_TAG = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [CPU_AW-1:0] addr_i,
  input  logic              busy_i,
  output logic              edge_o,
  output logic              in_win_o,
  output logic              start_o,
  output logic              start_wr_o
);
  import sram_share_pkg::*;

  localparam int unsigned TAG_W = CPU_AW - SRAM_AW;

  logic rd_q, wr_q;
  logic rd_rise, wr_rise;

  function automatic logic tag_hit(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1 -: TAG_W] == WIN_TAG;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_en_i;
      wr_q <= wr_en_i;
    end
  end

  always_comb begin
    rd_rise    = rose(rd_en_i, rd_q);
    wr_rise    = rose(wr_en_i, wr_q);
    edge_o     = rd_rise | wr_rise;
    in_win_o   = tag_hit(addr_i);
    start_o    = rst_n & edge_o & in_win_o & ~busy_i;
    start_wr_o = wr_rise;
  end

endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq #(
  parameter int unsigned SRAM_AW    = 20,
  parameter int unsigned ACC_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               start_wr_i,
  input  logic [SRAM_AW-1:0] addr_i,
  input  logic [1:0]         be_i,
  input  logic [15:0]        wdata_i,
  input  logic [15:0]        sram_rd_i,
  output logic               busy_o,
  output logic               strobe_o,
  output logic               ack_o,
  output logic               lat_wr_o,
  output logic [SRAM_AW-1:0] lat_addr_o,
  output logic [1:0]         lat_be_o,
  output logic [15:0]        lat_wdata_o,
  output logic [15:0]        rdata_o
);

  localparam int unsigned CW = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_PH   = CW'(ACC_CYCLES - 1);
  localparam logic [CW-1:0] STROBE_PH = CW'(ACC_CYCLES / 2);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o      <= 1'b0;
      phase       <= '0;
      ack_o       <= 1'b0;
      lat_wr_o    <= 1'b0;
      lat_addr_o  <= '0;
      lat_be_o    <= '0;
      lat_wdata_o <= '0;
      rdata_o     <= '0;
    end else begin
      ack_o <= 1'b0;
      if (busy_o) begin
        if (phase == LAST_PH) begin
          busy_o <= 1'b0;
          phase  <= '0;
          ack_o  <= 1'b1;
          if (!lat_wr_o) rdata_o <= sram_rd_i;
        end else begin
          phase <= phase + 1'b1;
        end
      end else if (start_i) begin
        busy_o      <= 1'b1;
        phase       <= '0;
        lat_wr_o    <= start_wr_i;
        lat_addr_o  <= addr_i;
        lat_be_o    <= be_i;
        lat_wdata_o <= wdata_i;
      end
    end
  end

  assign strobe_o = busy_o & lat_wr_o & (phase == STROBE_PH);

endmodule

// File: rtl/sram_pin_mux.sv
module sram_pin_mux #(
  parameter int unsigned SRAM_AW = 20
) (
  input  logic               busy_i,
  input  logic               strobe_i,
  input  logic               wr_i,
  input  logic [SRAM_AW-1:0] cpu_addr_i,
  input  logic [1:0]         be_i,
  input  logic [15:0]        wdata_i,
  input  logic [SRAM_AW-1:0] vid_addr_i,
  input  logic [15:0]        sram_dq_i,
  output logic [15:0]        vid_pix_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic [15:0]        sram_dq_o,
  output logic               sram_dq_oe_o,
  output logic               sram_we_n_o,
  output logic               sram_oe_n_o,
  output logic               sram_ub_n_o,
  output logic               sram_lb_n_o
);
  import sram_share_pkg::*;

  logic       cpu_wr;
  logic [1:0] sel_n;

  always_comb begin
    cpu_wr       = busy_i & wr_i;
    sel_n        = lane_sel_n(cpu_wr, be_i);
    sram_addr_o  = busy_i ? cpu_addr_i : vid_addr_i;
    sram_dq_o    = wdata_i;
    sram_dq_oe_o = cpu_wr;
    sram_we_n_o  = ~strobe_i;
    sram_oe_n_o  = cpu_wr;
    sram_ub_n_o  = sel_n[1];
    sram_lb_n_o  = sel_n[0];
    vid_pix_o    = sram_dq_i;
  end

endmodule

// File: rtl/sram_share_glue.sv
module sram_share_glue #(
  parameter int unsigned CPU_AW     = 24,
  parameter int unsigned SRAM_AW    = 20,
  parameter logic [CPU_AW-SRAM_AW-1:0] WIN_TAG = 4'h2,
  parameter int unsigned ACC_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_rd_en,
  input  logic               cpu_wr_en,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [1:0]         cpu_be,
  input  logic [15:0]        cpu_wdata,
  output logic [15:0]        cpu_rdata,
  output logic               cpu_ack,
  input  logic [SRAM_AW-1:0] vid_addr,
  output logic [15:0]        vid_pix,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [15:0]        sram_dq_o,
  output logic               sram_dq_oe,
  input  logic [15:0]        sram_dq_i,
  output logic               sram_we_n,
  output logic               sram_oe_n,
  output logic               sram_ub_n,
  output logic               sram_lb_n
);

  logic               req_edge, req_in_win, req_start, req_start_wr;
  logic               acc_busy, acc_strobe;
  logic               lat_wr;
  logic [SRAM_AW-1:0] lat_addr;
  logic [1:0]         lat_be;
  logic [15:0]        lat_wdata;

  sram_req_detect #(.CPU_AW(CPU_AW), .SRAM_AW(SRAM_AW), .WIN_TAG(WIN_TAG)) u_detect (
    .clk(clk), .rst_n(rst_n), .rd_en_i(cpu_rd_en), .wr_en_i(cpu_wr_en),
    .addr_i(cpu_addr), .busy_i(acc_busy), .edge_o(req_edge),
    .in_win_o(req_in_win), .start_o(req_start), .start_wr_o(req_start_wr)
  );

  sram_cycle_seq #(.SRAM_AW(SRAM_AW), .ACC_CYCLES(ACC_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(req_start), .start_wr_i(req_start_wr),
    .addr_i(cpu_addr[SRAM_AW-1:0]), .be_i(cpu_be), .wdata_i(cpu_wdata),
    .sram_rd_i(sram_dq_i), .busy_o(acc_busy), .strobe_o(acc_strobe),
    .ack_o(cpu_ack), .lat_wr_o(lat_wr), .lat_addr_o(lat_addr),
    .lat_be_o(lat_be), .lat_wdata_o(lat_wdata), .rdata_o(cpu_rdata)
  );

  sram_pin_mux #(.SRAM_AW(SRAM_AW)) u_mux (
    .busy_i(acc_busy), .strobe_i(acc_strobe), .wr_i(lat_wr),
    .cpu_addr_i(lat_addr), .be_i(lat_be), .wdata_i(lat_wdata),
    .vid_addr_i(vid_addr), .sram_dq_i(sram_dq_i), .vid_pix_o(vid_pix),
    .sram_addr_o(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe),
    .sram_we_n_o(sram_we_n), .sram_oe_n_o(sram_oe_n),
    .sram_ub_n_o(sram_ub_n), .sram_lb_n_o(sram_lb_n)
  );

endmodule

// File: rtl/sram_share_glue_chk.sv
module sram_share_glue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_start,
  input logic        acc_busy,
  input logic        cpu_ack,
  input logic        sram_we_n,
  input logic [15:0] cpu_rdata
);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack); // R3

  AST_ACK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> $past(req_start, 4)); // R3

  AST_START_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_start, 4) |-> cpu_ack); // R3

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n); // R5

  AST_WE_MIDDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $past(req_start, 2)); // R5

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_busy |-> !req_start); // R7

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ack |-> $stable(cpu_rdata)); // R6

endmodule

bind sram_share_glue sram_share_glue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .acc_busy(acc_busy),
  .cpu_ack(cpu_ack), .sram_we_n(sram_we_n), .cpu_rdata(cpu_rdata)
);

// File: tb/sram_share_glue_bench.sv
module sram_share_glue_bench;
  localparam int CPU_AW = 24;
  localparam int SRAM_AW = 20;
  localparam logic [3:0] TAG = 4'h2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [CPU_AW-1:0] addr = '0;
  logic [1:0] be = 2'b11;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ack;
  logic [SRAM_AW-1:0] vaddr = '0;
  logic [15:0] vpix;
  logic [SRAM_AW-1:0] s_addr;
  logic [15:0] s_dq_o, s_dq_i;
  logic s_oe, s_we_n, s_oe_n, s_ub_n, s_lb_n;

  int checks = 0, fails = 0, acks = 0;
  logic [15:0] mem [int];

  always #4 clk = ~clk;

  sram_share_glue u_sram_share_glue (
    .clk(clk), .rst_n(rst_n), .cpu_rd_en(rd_en), .cpu_wr_en(wr_en),
    .cpu_addr(addr), .cpu_be(be), .cpu_wdata(wdata), .cpu_rdata(rdata),
    .cpu_ack(ack), .vid_addr(vaddr), .vid_pix(vpix), .sram_addr(s_addr),
    .sram_dq_o(s_dq_o), .sram_dq_oe(s_oe), .sram_dq_i(s_dq_i),
    .sram_we_n(s_we_n), .sram_oe_n(s_oe_n), .sram_ub_n(s_ub_n), .sram_lb_n(s_lb_n)
  );

  function automatic logic [15:0] rd_mem(input logic [SRAM_AW-1:0] a);
    int k = int'(a);
    return mem.exists(k) ? mem[k] : (16'(a) ^ 16'h5A3C);
  endfunction

  always_comb s_dq_i = s_oe ? s_dq_o : rd_mem(s_addr);

  // external SRAM model: lane-gated write while the strobe is low
  always @(posedge clk) begin
    if (!s_we_n) begin
      logic [15:0] cur;
      cur = rd_mem(s_addr);
      if (!s_ub_n) cur[15:8] = s_dq_o[15:8];
      if (!s_lb_n) cur[7:0] = s_dq_o[7:0];
      mem[int'(s_addr)] = cur;
    end
    if (ack) acks++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0;
  bit m_prd = 0, m_pwr = 0, m_wr = 0, m_ack = 0;
  int m_addr = 0, m_be = 0, m_wdata = 0, m_rdata = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_pwr = 0; m_ack = 0; m_rdata = 0;
    end else begin
      bit rise, old_idle;
      old_idle = (m_cnt == 0);
      m_ack = 0;
      if (m_cnt == 3) begin
        m_ack = 1; m_cnt = 0;
        if (!m_wr) m_rdata = int'(rd_mem(m_addr[SRAM_AW-1:0]));
      end else if (m_cnt > 0) m_cnt++;
      rise = (rd_en && !m_prd) || (wr_en && !m_pwr);
      if (old_idle && rise && addr[CPU_AW-1 -: 4] == TAG) begin
        m_cnt = 1; m_wr = wr_en && !m_pwr;
        m_addr = int'(addr[SRAM_AW-1:0]); m_be = int'(be); m_wdata = int'(wdata);
      end
      m_prd = rd_en; m_pwr = wr_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit wr_act;
      wr_act = (m_cnt != 0) && m_wr;
      check(ack == m_ack, "R3", ack, m_ack);
      check(int'(rdata) == m_rdata, "R6", rdata, m_rdata);
      check(s_we_n == !(m_cnt == 2 && m_wr), "R5", s_we_n, !(m_cnt == 2 && m_wr));
      check(s_oe == wr_act, "R2", s_oe, wr_act);
      if (m_cnt != 0) check(int'(s_addr) == m_addr, "R4", s_addr, m_addr);
      else check(s_addr == vaddr, "R4", s_addr, vaddr);
      if (wr_act) begin
        check(int'(s_dq_o) == m_wdata && s_oe_n, "R5", s_dq_o, m_wdata);
        check({s_ub_n, s_lb_n} == ~2'(m_be), "R5", {s_ub_n, s_lb_n}, ~2'(m_be));
        check(int'(vpix) == m_wdata, "R9", vpix, m_wdata);
      end else if (m_cnt != 0) begin
        check({s_ub_n, s_lb_n, s_oe_n} == 3'b000, "R6", {s_ub_n, s_lb_n, s_oe_n}, 0);
      end else begin
        check(vpix == rd_mem(vaddr), "R9", vpix, rd_mem(vaddr));
      end
    end
    vaddr <= vaddr + 20'd7;
  end

  task automatic access(input bit w, input logic [19:0] a, input logic [1:0] b,
                        input logic [15:0] d, input logic [3:0] tag);
    @(negedge clk);
    addr = {tag, a}; be = b; wdata = d;
    if (w) wr_en = 1; else rd_en = 1;
    repeat (7) @(negedge clk);
    rd_en = 0; wr_en = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(ack == 0 && s_we_n == 1 && rdata == 0, "R10", {ack, s_we_n, rdata}, 17'h10000);
    check(s_addr == vaddr, "R10", s_addr, vaddr);
    rst_n = 1;
    @(negedge clk);

    // R1 read of an untouched word
    a0 = acks;
    access(0, 20'h00123, 2'b11, 0, TAG);
    check(rdata == (16'h0123 ^ 16'h5A3C), "R1", rdata, 16'h0123 ^ 16'h5A3C);
    check(acks - a0 == 1, "R8", acks - a0, 1);

    // R5 byte-lane writes then readback
    access(1, 20'h00040, 2'b11, 16'hBEEF, TAG);
    access(1, 20'h00040, 2'b10, 16'h12FF, TAG);
    access(1, 20'h00040, 2'b01, 16'hFF34, TAG);
    check(rdata == (16'h0123 ^ 16'h5A3C), "R6", rdata, 16'h0123 ^ 16'h5A3C);
    access(0, 20'h00040, 2'b00, 0, TAG);
    check(rdata == 16'h1234, "R5", rdata, 16'h1234);

    // R2 out-of-window write leaves SRAM untouched
    a0 = acks;
    access(1, 20'h00040, 2'b11, 16'h0000, 4'h3);
    check(acks == a0, "R2", acks - a0, 0);
    access(0, 20'h00040, 2'b11, 0, TAG);
    check(rdata == 16'h1234, "R2", rdata, 16'h1234);

    // R7 strobe re-raised mid-access is ignored
    a0 = acks;
    @(negedge clk);
    addr = {TAG, 20'h00077}; rd_en = 1;
    @(negedge clk); rd_en = 0;
    @(negedge clk); rd_en = 1;
    repeat (6) @(negedge clk);
    rd_en = 0;
    repeat (2) @(negedge clk);
    check(acks - a0 == 1, "R7", acks - a0, 1);

    // R1 write strobe wins when both rise
    @(negedge clk);
    addr = {TAG, 20'h00050}; be = 2'b11; wdata = 16'hC0DE; rd_en = 1; wr_en = 1;
    repeat (6) @(negedge clk);
    rd_en = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    access(0, 20'h00050, 2'b11, 0, TAG);
    check(rdata == 16'hC0DE, "R1", rdata, 16'hC0DE);

    // R8 held strobe, back-to-back accesses
    a0 = acks;
    @(negedge clk);
    addr = {TAG, 20'h00050}; rd_en = 1;
    repeat (20) @(negedge clk);
    check(acks - a0 == 1, "R8", acks - a0, 1);
    rd_en = 0;
    @(negedge clk);
    access(0, 20'hFFFFF, 2'b11, 0, TAG);
    check(rdata == (16'hFFFF ^ 16'h5A3C), "R4", rdata, 16'hFFFF ^ 16'h5A3C);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule